// File: doc/BRIEF.md
# Scatter-Gather DMA Write Engine

This engine drains a stream of 256-bit words from a first-word-fall-through FIFO and turns it into memory-write bursts aimed at host or accelerator memory. The host fills a small on-chip table of destination buffers (a 64-bit physical address and a byte length of up to 2^31 per entry), sets how many entries are valid, sets the largest burst payload, and writes a start command. The engine then visits the table in index order. It cuts each buffer into bursts that never exceed the payload limit and never cross a 4 KB address boundary. After the last valid entry it sends one extra single-beat write to a notification address chosen by the host. That write carries the total number of bytes moved.

A latency timer runs from the accepted start command until the host writes the stop command. The host can read it back with a resolution of one clock cycle. The host may rewrite the table between transfers. Lengths and addresses are expected to be multiples of the 32-byte beat size.

Register words (32 bits, word index): 0 command (bit0 start, bit1 stop), 1 status, 2 entry count, 3 maximum payload in bytes, 4/5 notification address low/high, 6 latency, 7 table index select, 8/9 entry address low/high, 10 entry length.

Top module: `dma_sg_writer`

## Requirements
- R1: After reset the status word reads 0, the latency word reads 0 and out_valid is low.
- R2: When the engine is idle, writing word 0 with bit0 set starts a transfer at table entry 0. Status bit0 (busy) reads 1 until the notification write is accepted.
- R3: Each burst presents its address and beat count (bytes/32) on every beat, with first/last flags. Beats go to consecutive addresses with the FIFO words in order. A burst never exceeds the effective payload, which is word 3 rounded down to a multiple of 32 and clamped to the range 32 to 4096 bytes.
- R4: No burst crosses a 4096-byte address boundary. A buffer that reaches one is split at that boundary.
- R5: Entries 0 to count-1 (word 2) are visited in order, and an entry with length 0 produces no burst.
- R6: A data beat is offered only while the FIFO is non-empty. A FIFO word is popped exactly when a beat is accepted. Address and count hold steady while a beat waits for ready.
- R7: After the last entry, one single-beat write with out_notify high goes to the address in words 5:4. The low 32 data bits hold the total byte count. Once it is accepted, status reads busy=0 and done=1 (bit1).
- R8: With an entry count of 0, a start produces only the notification write, carrying 0 bytes.
- R9: A start command written while busy is ignored. It neither restarts the latency timer nor begins a second transfer.
- R10: Word 6 holds the number of clock cycles from the accepted start write to the stop write (bit1 of word 0), and stays frozen after the stop.
- R11: Table entries are written by selecting an index in word 7 and then writing words 8, 9 and 10. A rewritten entry takes effect in the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word index |
| reg_rdata | output | 32 | Registered read data, one cycle after reg_raddr |
| in_data | input | 256 | FIFO head word |
| in_empty | input | 1 | FIFO empty flag |
| in_rd | output | 1 | FIFO pop |
| out_valid | output | 1 | Write beat valid |
| out_ready | input | 1 | Write beat accepted |
| out_addr | output | 64 | Burst start address |
| out_beats | output | 8 | Beats in burst |
| out_first | output | 1 | First beat of burst |
| out_last | output | 1 | Last beat of burst |
| out_notify | output | 1 | Beat is the completion notification |
| out_data | output | 256 | Beat data |

## Verification
The bursting function is driven with four kinds of pattern:
- a single aligned buffer with the sink always ready, which checks basic beat order and counts;
- a buffer that starts 128 bytes below a 4 KB boundary, which separates boundary splitting from payload splitting;
- a multi-entry table with a zero-length entry, a smaller payload limit and a sink that stalls at random, which tests entry order, skipping and stall holding;
- an empty table, which isolates the notification path.

Separate runs cover the start-while-busy case with the FIFO held empty and the exact latency count. Every accepted beat is compared with a model built from the requirements.

// File: rtl/dma_sg_pkg.sv
package dma_sg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_FETCH, ST_CALC, ST_BURST, ST_NOTIFY
  } dma_state_t;

  localparam int REG_AW      = 4;
  localparam int RW_CMD      = 0;
  localparam int RW_STATUS   = 1;
  localparam int RW_COUNT    = 2;
  localparam int RW_MAXPAY   = 3;
  localparam int RW_NTF_LO   = 4;
  localparam int RW_NTF_HI   = 5;
  localparam int RW_LATENCY  = 6;
  localparam int RW_SEL      = 7;
  localparam int RW_ENT_LO   = 8;
  localparam int RW_ENT_HI   = 9;
  localparam int RW_ENT_LEN  = 10;
endpackage

// File: rtl/dma_sg_ram.sv
module dma_sg_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dma_sg_regs.sv
module dma_sg_regs
  import dma_sg_pkg::*;
#(
  parameter int NUM_DESC = 16,
  parameter int LAT_W    = 32,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic              start_ok,
  output logic [IDX_W:0]    entry_count,
  output logic [31:0]       max_pay,
  output logic [63:0]       notify_addr,
  output logic [IDX_W-1:0]  ent_sel,
  output logic [2:0]        ent_we
);
  logic [LAT_W-1:0] lat_cnt;
  logic             lat_run;
  logic             cmd_wr, stop_req;

  assign cmd_wr   = reg_wr && (reg_waddr == REG_AW'(RW_CMD));
  assign start_ok = cmd_wr && reg_wdata[0] && !busy;
  assign stop_req = cmd_wr && reg_wdata[1];

  assign ent_we[0] = reg_wr && (reg_waddr == REG_AW'(RW_ENT_LO));
  assign ent_we[1] = reg_wr && (reg_waddr == REG_AW'(RW_ENT_HI));
  assign ent_we[2] = reg_wr && (reg_waddr == REG_AW'(RW_ENT_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_count <= '0;
      max_pay     <= '0;
      notify_addr <= '0;
      ent_sel     <= '0;
    end else if (reg_wr) begin
      case (reg_waddr)
        REG_AW'(RW_COUNT):
          entry_count <= (reg_wdata > 32'(NUM_DESC)) ? (IDX_W+1)'(NUM_DESC)
                                                     : reg_wdata[IDX_W:0];
        REG_AW'(RW_MAXPAY): max_pay <= reg_wdata;
        REG_AW'(RW_NTF_LO): notify_addr[31:0]  <= reg_wdata;
        REG_AW'(RW_NTF_HI): notify_addr[63:32] <= reg_wdata;
        REG_AW'(RW_SEL):    ent_sel <= reg_wdata[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  // round-trip timer: zeroed on an accepted start, counts each later edge,
  // including the one that carries the stop command
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
      lat_run <= 1'b0;
    end else if (start_ok) begin
      lat_cnt <= '0;
      lat_run <= 1'b1;
    end else if (lat_run) begin
      lat_cnt <= lat_cnt + 1'b1;
      if (stop_req) lat_run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_raddr)
        REG_AW'(RW_STATUS):  reg_rdata <= {16'd0, 8'(cur_idx), 6'd0, done, busy};
        REG_AW'(RW_COUNT):   reg_rdata <= 32'(entry_count);
        REG_AW'(RW_MAXPAY):  reg_rdata <= max_pay;
        REG_AW'(RW_NTF_LO):  reg_rdata <= notify_addr[31:0];
        REG_AW'(RW_NTF_HI):  reg_rdata <= notify_addr[63:32];
        REG_AW'(RW_LATENCY): reg_rdata <= 32'(lat_cnt);
        REG_AW'(RW_SEL):     reg_rdata <= 32'(ent_sel);
        default:             reg_rdata <= '0;
      endcase
    end
  end

  // R10: once stopped, the timer holds until the next accepted start
  assert_lat_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!lat_run && !start_ok) |=> $stable(lat_cnt));

  // R9: a start command seen while busy does not zero a running timer
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && reg_wdata[0] && busy && lat_run && !stop_req)
      |=> (lat_cnt == $past(lat_cnt) + 1'b1));
endmodule

// File: rtl/dma_sg_burst.sv
module dma_sg_burst
  import dma_sg_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 256,
  parameter int LEN_W    = 32,
  parameter int NUM_DESC = 16,
  parameter int BOUNDARY = 4096,
  localparam int IDX_W      = $clog2(NUM_DESC),
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int BSH        = $clog2(BEAT_BYTES),
  localparam int BND_W      = $clog2(BOUNDARY),
  localparam int BEATS_W    = BND_W - BSH + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [IDX_W:0]     entry_count,
  input  logic [31:0]        max_pay,
  input  logic [ADDR_W-1:0]  notify_addr,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic [ADDR_W-1:0]  d_addr,
  input  logic [LEN_W-1:0]   d_len,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_empty,
  output logic               in_rd,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [BEATS_W-1:0] out_beats,
  output logic               out_first,
  output logic               out_last,
  output logic               out_notify,
  output logic [DATA_W-1:0]  out_data,
  output logic               busy,
  output logic               done
);
  dma_state_t        st;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] cur_addr, bst_addr;
  logic [LEN_W-1:0]  rem;
  logic [BEATS_W-1:0] bst_beats, beat_cnt;
  logic [63:0]       tot_bytes;

  logic [LEN_W-1:0]  rem_al, mp_eff, room, chunk, chunk_beats;
  logic [BND_W:0]    room_n;
  logic [IDX_W:0]    idx_next;
  logic              fire, last_beat;

  always_comb begin
    rem_al = rem & ~LEN_W'(BEAT_BYTES - 1);
    if (max_pay < 32'(BEAT_BYTES))      mp_eff = LEN_W'(BEAT_BYTES);
    else if (max_pay > 32'(BOUNDARY))   mp_eff = LEN_W'(BOUNDARY);
    else mp_eff = LEN_W'(max_pay) & ~LEN_W'(BEAT_BYTES - 1);
    room_n = (BND_W+1)'(BOUNDARY) - {1'b0, cur_addr[BND_W-1:0]};
    room   = LEN_W'(room_n);
    chunk  = rem_al;
    if (mp_eff < chunk) chunk = mp_eff;
    if (room < chunk)   chunk = room;
    chunk_beats = chunk >> BSH;
  end

  assign idx_next  = {1'b0, idx} + 1'b1;
  assign rd_idx    = idx;
  assign fire      = (st == ST_BURST) && !in_empty && out_ready;
  assign last_beat = (beat_cnt == bst_beats - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      cur_addr  <= '0;
      bst_addr  <= '0;
      rem       <= '0;
      bst_beats <= '0;
      beat_cnt  <= '0;
      tot_bytes <= '0;
      done      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          idx       <= '0;
          tot_bytes <= '0;
          done      <= 1'b0;
          st        <= (entry_count == '0) ? ST_NOTIFY : ST_LOAD;
        end
        ST_LOAD:  st <= ST_FETCH;
        ST_FETCH: begin
          cur_addr <= d_addr;
          rem      <= d_len;
          st       <= ST_CALC;
        end
        ST_CALC: begin
          if (rem_al == '0) begin
            if (idx_next == entry_count) st <= ST_NOTIFY;
            else begin
              idx <= idx_next[IDX_W-1:0];
              st  <= ST_LOAD;
            end
          end else begin
            bst_addr  <= cur_addr;
            bst_beats <= chunk_beats[BEATS_W-1:0];
            beat_cnt  <= '0;
            cur_addr  <= cur_addr + ADDR_W'(chunk);
            rem       <= rem - chunk;
            tot_bytes <= tot_bytes + 64'(chunk);
            st        <= ST_BURST;
          end
        end
        ST_BURST: if (fire) begin
          beat_cnt <= beat_cnt + 1'b1;
          if (last_beat) st <= ST_CALC;
        end
        ST_NOTIFY: if (out_ready) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign out_notify = (st == ST_NOTIFY);
  assign out_valid  = ((st == ST_BURST) && !in_empty) || out_notify;
  assign in_rd      = fire;
  assign out_addr   = out_notify ? notify_addr : bst_addr;
  assign out_beats  = out_notify ? BEATS_W'(1) : bst_beats;
  assign out_first  = out_notify || (beat_cnt == '0);
  assign out_last   = out_notify || last_beat;
  assign out_data   = out_notify ? DATA_W'(tot_bytes) : in_data;

  assert_no_4k_cross_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_notify && out_first)
      |-> ({1'b0, out_addr[BND_W-1:0]} + ((BND_W+1)'(out_beats) << BSH))
          <= (BND_W+1)'(BOUNDARY));

  assert_payload_limit_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_notify) |-> ((out_beats != '0) &&
      ((LEN_W'(out_beats) << BSH) <= mp_eff)));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_addr) && $stable(out_beats)
                                   && $stable(out_notify)));

  assert_empty_no_beat_R6: assert property (@(posedge clk) disable iff (rst)
    (in_empty && !out_notify) |-> !out_valid);

  assert_single_notify_R7: assert property (@(posedge clk) disable iff (rst)
    (out_notify && out_ready) |=> (!out_notify && done && !busy));
endmodule

// File: rtl/dma_sg_writer.sv
module dma_sg_writer
  import dma_sg_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 256,
  parameter int LEN_W    = 32,
  parameter int NUM_DESC = 16,
  parameter int BOUNDARY = 4096,
  parameter int LAT_W    = 32,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int BEATS_W = $clog2(BOUNDARY) - $clog2(DATA_W / 8) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_waddr,
  input  logic [31:0]        reg_wdata,
  input  logic [REG_AW-1:0]  reg_raddr,
  output logic [31:0]        reg_rdata,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_empty,
  output logic               in_rd,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [BEATS_W-1:0] out_beats,
  output logic               out_first,
  output logic               out_last,
  output logic               out_notify,
  output logic [DATA_W-1:0]  out_data
);
  logic             busy, done, start_ok;
  logic [IDX_W:0]   entry_count;
  logic [31:0]      max_pay;
  logic [63:0]      notify_addr;
  logic [IDX_W-1:0] ent_sel, rd_idx;
  logic [2:0]       ent_we;
  logic [31:0]      ent_q [3];

  dma_sg_regs #(.NUM_DESC(NUM_DESC), .LAT_W(LAT_W)) u_regs (
    .clk, .rst, .reg_wr, .reg_waddr, .reg_wdata, .reg_raddr, .reg_rdata,
    .busy, .done, .cur_idx(rd_idx), .start_ok, .entry_count, .max_pay,
    .notify_addr, .ent_sel, .ent_we
  );

  // one table column per field: address low, address high, length
  for (genvar g = 0; g < 3; g++) begin : g_table
    dma_sg_ram #(.WIDTH(32), .DEPTH(NUM_DESC)) u_col (
      .clk, .we(ent_we[g]), .waddr(ent_sel), .wdata(reg_wdata),
      .raddr(rd_idx), .rdata(ent_q[g])
    );
  end

  dma_sg_burst #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .NUM_DESC(NUM_DESC), .BOUNDARY(BOUNDARY)
  ) u_burst (
    .clk, .rst, .start(start_ok), .entry_count, .max_pay,
    .notify_addr(ADDR_W'(notify_addr)), .rd_idx,
    .d_addr(ADDR_W'({ent_q[1], ent_q[0]})), .d_len(LEN_W'(ent_q[2])),
    .in_data, .in_empty, .in_rd, .out_valid, .out_ready, .out_addr,
    .out_beats, .out_first, .out_last, .out_notify, .out_data, .busy, .done
  );
endmodule

// File: tb/dma_sg_writer_tb.sv
module dma_sg_writer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         reg_wr = 1'b0;
  logic [3:0]   reg_waddr = '0, reg_raddr = '0;
  logic [31:0]  reg_wdata = '0, reg_rdata;
  logic [255:0] in_data;
  logic         in_empty, in_rd, out_valid, out_first, out_last, out_notify;
  logic         out_ready = 1'b1;
  logic [63:0]  out_addr;
  logic [7:0]   out_beats;
  logic [255:0] out_data;

  dma_sg_writer u_dut (
    .clk, .rst, .reg_wr, .reg_waddr, .reg_wdata, .reg_raddr, .reg_rdata,
    .in_data, .in_empty, .in_rd, .out_valid, .out_ready, .out_addr,
    .out_beats, .out_first, .out_last, .out_notify, .out_data
  );

  int checks = 0, failures = 0;
  localparam logic [63:0] NTF = 64'h0000_00AB_CDEF_0040;

  // FIFO model: word n carries tag D0000000+n
  int fifo_ptr = 0, fifo_avail = 0;
  assign in_empty = (fifo_ptr >= fifo_avail);
  assign in_data  = {8{32'hD000_0000 + 32'(fifo_ptr)}};
  always @(posedge clk) if (in_rd) fifo_ptr <= fifo_ptr + 1;

  // expected beat list
  logic [63:0] e_addr [256];
  logic [7:0]  e_beats [256];
  logic [2:0]  e_flags [256];
  logic [31:0] e_data [256];
  int exp_n = 0, mon_idx = 0;
  logic [63:0] d_addr [4];
  logic [31:0] d_len [4];
  string cur_req = "R3";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ready pattern
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]);
    #1;
    if (!rst && out_valid && out_ready) begin
      if (mon_idx >= exp_n)
        check(0, cur_req, "unexpected beat", 128'(out_addr), 128'(0));
      else
        check({out_addr, out_beats, out_first, out_last, out_notify, out_data[31:0]} ==
              {e_addr[mon_idx], e_beats[mon_idx], e_flags[mon_idx], e_data[mon_idx]},
              cur_req, $sformatf("beat %0d", mon_idx),
              128'({out_addr, out_beats, out_first, out_last, out_notify, out_data[31:0]}),
              128'({e_addr[mon_idx], e_beats[mon_idx], e_flags[mon_idx], e_data[mon_idx]}));
      mon_idx++;
    end
  end

  task automatic reg_write(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_waddr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    reg_raddr = 4'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  // R11: select index, then address low/high and length
  task automatic put_entry(input int i, input logic [63:0] a, input logic [31:0] l);
    d_addr[i] = a; d_len[i] = l;
    reg_write(7, 32'(i));
    reg_write(8, a[31:0]);
    reg_write(9, a[63:32]);
    reg_write(10, l);
  endtask

  // expected bursts from R3/R4/R5/R7, independent of the design
  task automatic build_exp(input int n, input int mp);
    int w, mpe;
    longint tot;
    w = fifo_ptr; tot = 0; exp_n = 0; mon_idx = 0;
    mpe = (mp < 32) ? 32 : (mp > 4096) ? 4096 : (mp / 32) * 32;
    for (int i = 0; i < n; i++) begin
      longint a, r;
      a = longint'(d_addr[i]); r = longint'(d_len[i]);
      while (r > 0) begin
        longint b;
        b = r;
        if (mpe < b) b = mpe;
        if (4096 - (a % 4096) < b) b = 4096 - (a % 4096);
        for (int k = 0; k < b / 32; k++) begin
          e_addr[exp_n]  = 64'(a);
          e_beats[exp_n] = 8'(b / 32);
          e_flags[exp_n] = {k == 0, k == b / 32 - 1, 1'b0};
          e_data[exp_n]  = 32'hD000_0000 + 32'(w);
          w++; exp_n++;
        end
        a += b; r -= b; tot += b;
      end
    end
    e_addr[exp_n] = NTF; e_beats[exp_n] = 8'd1; e_flags[exp_n] = 3'b111;
    e_data[exp_n] = 32'(tot);
    exp_n++;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    s = '0;
    for (int t = 0; t < 4000; t++) begin
      reg_read(1, s);
      if (s[1]) break;
    end
    check(s[1:0] == 2'b10, "R7", {req, " done/busy after transfer"}, 128'(s[1:0]), 128'(2'b10));
    check(mon_idx == exp_n, req, "beat count", 128'(mon_idx), 128'(exp_n));
  endtask

  task automatic setup(input int n, input int mp);
    reg_write(2, 32'(n));
    reg_write(3, 32'(mp));
    reg_write(4, NTF[31:0]);
    reg_write(5, NTF[63:32]);
    build_exp(n, mp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_read(1, v);
    check(v == 0, "R1", "status after reset", 128'(v), 128'(0));
    reg_read(6, v);
    check(v == 0, "R1", "latency after reset", 128'(v), 128'(0));
    check(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 128'(0));
  endtask

  task automatic t_single;
    logic [31:0] v;
    cur_req = "R3"; rdy_mode = 0;
    put_entry(0, 64'h0000_0001_2000_0000, 32'd256);
    setup(1, 256);
    reg_write(0, 32'h1);
    repeat (3) @(negedge clk);
    reg_read(1, v);
    check(v[0] == 1'b1, "R2", "busy after start", 128'(v[0]), 128'(1));
    check(out_valid == 1'b0 && mon_idx == 0, "R6", "no beat while FIFO empty",
          128'(out_valid), 128'(0));
    fifo_avail = fifo_ptr + 8;
    wait_done("R3");
  endtask

  task automatic t_boundary;
    cur_req = "R4"; rdy_mode = 1;
    put_entry(0, 64'h0000_0000_3000_0F80, 32'd512);
    setup(1, 256);
    reg_write(0, 32'h1);
    fifo_avail = fifo_ptr + 16;
    wait_done("R4");
  endtask

  task automatic t_multi;
    cur_req = "R5"; rdy_mode = 1;
    put_entry(0, 64'h0000_0002_0000_1000, 32'd96);
    put_entry(1, 64'h0000_0002_0000_8000, 32'd0);
    put_entry(2, 64'h0000_0003_4000_0FC0, 32'd320);
    setup(3, 150);   // payload rounds down to 128 bytes
    reg_write(0, 32'h1);
    fifo_avail = fifo_ptr + 13;
    wait_done("R5");
    // R11: rewrite entry 0 and rerun a single-entry transfer with it
    cur_req = "R11"; rdy_mode = 0;
    put_entry(0, 64'h0000_0000_0000_2000, 32'd64);
    setup(1, 4096);
    reg_write(0, 32'h1);
    fifo_avail = fifo_ptr + 2;
    wait_done("R11");
  endtask

  task automatic t_empty_table;
    cur_req = "R8"; rdy_mode = 0;
    setup(0, 256);
    reg_write(0, 32'h1);
    wait_done("R8");
  endtask

  task automatic t_busy_start;
    logic [31:0] v;
    cur_req = "R9"; rdy_mode = 0;
    put_entry(0, 64'h0000_0000_5000_0000, 32'd128);
    setup(1, 256);
    reg_write(0, 32'h1);
    repeat (20) @(negedge clk);
    reg_write(0, 32'h1);
    reg_read(6, v);
    check(v >= 32'd21, "R9", "timer not restarted by busy start", 128'(v), 128'(21));
    fifo_avail = fifo_ptr + 4;
    wait_done("R9");
    repeat (10) @(negedge clk);
    check(mon_idx == exp_n && out_valid == 1'b0, "R9", "no second transfer",
          128'(mon_idx), 128'(exp_n));
    reg_write(0, 32'h2);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    cur_req = "R10"; rdy_mode = 0;
    setup(0, 256);
    reg_write(0, 32'h1);
    repeat (37) @(negedge clk);
    reg_write(0, 32'h2);
    reg_read(6, v);
    check(v == 32'd38, "R10", "latency count", 128'(v), 128'(38));
    repeat (15) @(negedge clk);
    reg_read(6, v);
    check(v == 32'd38, "R10", "latency frozen", 128'(v), 128'(38));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_boundary();
    t_multi();
    t_empty_table();
    t_busy_start();
    t_latency();
    summary();
    $finish;
  end
endmodule